// File: doc/BRIEF.md
# DMA Channel Request/Acknowledge Sequencer

This block runs the request side of one DMA channel. A peripheral raises a request line. The block synchronises that line into its own clock, answers with an acknowledge, and performs one atomic transfer made of one beat or a burst of four beats. The beats go out on a valid/ready interface toward the bus side. Each finished atomic transfer takes one off a loaded transfer count. When that count reaches zero the channel stops answering requests, and it can raise a single-cycle terminal-count interrupt.

Two acknowledge policies can be selected. In the waiting policy, the acknowledge stays high after a transfer until the request is seen low, so one request edge yields exactly one transfer. In the chaining policy, the acknowledge drops straight after a transfer and the next transfer starts as soon as the request is still seen high. A control write latches the policy, the burst size, the interrupt enable and the count. The write takes effect only while the channel is idle.

Top module: `xfer_req_seq`

## Requirements
- R1: After reset, `dack_out`, `beat_valid` and `tc_irq` are low and `remaining` is zero. The latched control fields reset to chaining policy, single beat and interrupt disabled.
- R2: `dreq_in` passes through a two-flop synchroniser. If `dreq_in` rises just after edge 0 on an idle channel with a nonzero count, `dack_out` is still low after edge 2 and goes high after edge 3.
- R3: While `remaining` is zero, the channel ignores `dreq_in`: `dack_out` and `beat_valid` stay low.
- R4: With `cfg_hs_mode`=0 (chaining), `dack_out` goes low in the cycle after the last beat of a transfer and stays low for at least one clock. If the request is still high, a new transfer then starts.
- R5: With `cfg_hs_mode`=1 (waiting), `dack_out` stays high after the last beat until the synchronised request is low. Only then does it drop. No new transfer starts while the request stays high.
- R6: `cfg_burst4`=0 gives one beat per transfer and `cfg_burst4`=1 gives four. A beat counts only when `beat_valid` and `beat_ready` are both high. `beat_valid` stays high through stalls, and the transfer does not end until the selected number of beats has been accepted.
- R7: `remaining` decrements by exactly one at the end of each atomic transfer.
- R8: With `cfg_irq_en`=1, `tc_irq` pulses high for exactly one cycle when `remaining` goes from 1 to 0. It pulses once per loaded count. With `cfg_irq_en`=0 it never pulses.
- R9: A `cfg_wr` is ignored while a transfer is running or the acknowledge is being held, and also in the cycle a transfer starts. In those cases `remaining` and the latched fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_hs_mode | input | 1 | 1: waiting policy, 0: chaining policy |
| cfg_burst4 | input | 1 | 1: four-beat burst, 0: single beat |
| cfg_irq_en | input | 1 | Terminal-count interrupt enable |
| cfg_count | input | CNT_W | Number of atomic transfers to perform |
| dreq_in | input | 1 | Asynchronous peripheral request |
| dack_out | output | 1 | Acknowledge to the peripheral |
| beat_valid | output | 1 | Beat offered to the bus side |
| beat_ready | input | 1 | Bus side accepts the beat |
| remaining | output | CNT_W | Transfers still to perform |
| tc_irq | output | 1 | Terminal-count interrupt pulse |

## Verification
The bench keeps the request held high in both policies. A design that chains in the waiting policy produces extra transfers. A design that never drops the acknowledge in the chaining policy merges two transfers into one long one, and the scoreboard catches both as a wrong transfer count or beat count. Four-beat bursts run against a toggling ready, so a design that counts offered beats instead of accepted beats ends too early. The bench also covers these cases:
- Requests against a zero count, which must produce no acknowledge.
- A control write during a held acknowledge, which must not change the count.
- Interrupt counts with the enable on and off, which catch double or missing pulses.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_HOLD = 2'd2
  } sq_state_t;

  // Index of the final beat for the selected atomic size.
  function automatic logic [1:0] final_beat_idx(input logic burst4);
    return burst4 ? 2'd3 : 2'd0;
  endfunction

  // Next value of the shortening transfer count (saturates at zero).
  function automatic logic [31:0] count_step(input logic [31:0] cur);
    return (cur == 32'd0) ? 32'd0 : cur - 32'd1;
  endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = sh[STAGES-1];
endmodule

// File: rtl/xrs_beats.sv
module xrs_beats
  import xrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic beat_fire,
  input  logic burst4,
  output logic last_fire
);
  logic [1:0] idx;
  logic [1:0] idx_end;

  assign idx_end   = final_beat_idx(burst4);
  assign last_fire = beat_fire && (idx == idx_end);

  always_ff @(posedge clk) begin
    if (!rst_n)         idx <= 2'd0;
    else if (start)     idx <= 2'd0;
    else if (last_fire) idx <= 2'd0;
    else if (beat_fire) idx <= idx + 2'd1;
  end

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= idx_end); // R6
endmodule

// File: rtl/xrs_count_irq.sv
module xrs_count_irq
  import xrs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             irq_en,
  output logic [CNT_W-1:0] remaining,
  output logic             nonzero,
  output logic             tc_irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [31:0] stepped;
  logic        hits_zero;

  assign stepped   = count_step(32'(remaining));
  assign nonzero   = (remaining != '0);
  assign hits_zero = dec && (remaining == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      tc_irq    <= 1'b0;
    end else begin
      if (load)     remaining <= load_val;
      else if (dec) remaining <= stepped[CNT_W-1:0];
      tc_irq <= hits_zero && irq_en;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && nonzero) |=> (remaining == $past(remaining) - ONE)); // R7
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |-> (remaining == '0)); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> !tc_irq); // R8
endmodule

// File: rtl/xfer_req_seq.sv
module xfer_req_seq
  import xrs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_hs_mode,
  input  logic             cfg_burst4,
  input  logic             cfg_irq_en,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             dreq_in,
  output logic             dack_out,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [CNT_W-1:0] remaining,
  output logic             tc_irq
);
  sq_state_t state, state_nx;

  logic hs_q, b4_q, ie_q;
  logic dreq_s;
  logic cnt_nz;
  logic start_ev;
  logic beat_fire;
  logic xfer_end;
  logic cfg_take;
  logic in_idle;

  xrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(dreq_in), .d_sync(dreq_s)
  );

  assign in_idle   = (state == SQ_IDLE);
  assign start_ev  = in_idle && cnt_nz && dreq_s;
  assign cfg_take  = cfg_wr && in_idle && !start_ev;
  assign beat_fire = beat_valid && beat_ready;

  xrs_beats u_beats (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .beat_fire(beat_fire),
    .burst4(b4_q), .last_fire(xfer_end)
  );

  xrs_count_irq #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cfg_take), .load_val(cfg_count),
    .dec(xfer_end), .irq_en(ie_q), .remaining(remaining),
    .nonzero(cnt_nz), .tc_irq(tc_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      b4_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (cfg_take) begin
      hs_q <= cfg_hs_mode;
      b4_q <= cfg_burst4;
      ie_q <= cfg_irq_en;
    end
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE: if (start_ev) state_nx = SQ_XFER;
      SQ_XFER: if (xfer_end) state_nx = hs_q ? SQ_HOLD : SQ_IDLE;
      SQ_HOLD: if (!dreq_s)  state_nx = SQ_IDLE;
      default: state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nx;
  end

  assign dack_out   = (state == SQ_XFER) || (state == SQ_HOLD);
  assign beat_valid = (state == SQ_XFER);

  AST_EMPTY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !cnt_nz) |=> !dack_out); // R3
  AST_DEMAND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !hs_q) |=> !dack_out); // R4
  AST_HS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && hs_q) |=> dack_out); // R5
  AST_HS_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_HOLD && dreq_s) |=> dack_out); // R5
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> beat_valid); // R6
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> ($stable(hs_q) && $stable(b4_q) && $stable(ie_q))); // R9
endmodule

// File: tb/xfer_req_seq_tb.sv
module xfer_req_seq_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic             cfg_hs_mode = 1'b0;
  logic             cfg_burst4 = 1'b0;
  logic             cfg_irq_en = 1'b0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic             dreq_in = 1'b0;
  logic             dack_out;
  logic             beat_valid;
  logic             beat_ready = 1'b1;
  logic [CNT_W-1:0] remaining;
  logic             tc_irq;

  int n_checks = 0;
  int n_errors = 0;
  int irq_seen = 0;
  int xfers_seen = 0;
  bit rdy_toggle = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  xfer_req_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hs_mode(cfg_hs_mode),
    .cfg_burst4(cfg_burst4), .cfg_irq_en(cfg_irq_en), .cfg_count(cfg_count),
    .dreq_in(dreq_in), .dack_out(dack_out), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .remaining(remaining), .tc_irq(tc_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected beats per atomic transfer: 1 or 4 (restated from R6).
  function automatic int beats_of(input bit b4);
    return b4 ? 4 : 1;
  endfunction

  task automatic push_xfers(input int n, input bit b4);
    for (int i = 0; i < n; i++) exp_q.push_back(beats_of(b4));
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input bit hs, input bit b4, input bit ie, input int cnt);
    @(posedge clk); #1;
    cfg_hs_mode = hs; cfg_burst4 = b4; cfg_irq_en = ie;
    cfg_count = CNT_W'(cnt); cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (rdy_toggle) beat_ready = ~beat_ready;
    else            beat_ready = 1'b1;
  end

  // Monitor / scoreboard
  int  beat_acc = 0;
  bit  dack_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tc_irq) irq_seen++;
      if (dack_out && beat_valid && beat_ready) beat_acc++;
      if (dack_prev && !dack_out) begin
        xfers_seen++;
        if (exp_q.size() == 0) chk(0, "R4/R5 unexpected transfer", beat_acc, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(beat_acc == e, "R6 beats per transfer", beat_acc, e);
        end
        beat_acc = 0;
      end
      dack_prev = dack_out;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    step(4);
    // R1 reset state
    chk(dack_out == 0, "R1 dack", dack_out, 0);
    chk(beat_valid == 0, "R1 beat_valid", beat_valid, 0);
    chk(remaining == 0, "R1 remaining", int'(remaining), 0);
    chk(tc_irq == 0, "R1 tc_irq", tc_irq, 0);
    rst_n = 1'b1;
    step(2);

    // R3 zero count ignores the request
    dreq_in = 1'b1;
    step(12);
    chk(dack_out == 0, "R3 no dack at zero count", dack_out, 0);
    chk(xfers_seen == 0, "R3 no transfer", xfers_seen, 0);
    dreq_in = 1'b0;
    step(4);

    // R2/R4/R7/R8 chaining, single beat, count 3, irq on
    load(1'b0, 1'b0, 1'b1, 3);
    chk(remaining == 3, "R7 load", int'(remaining), 3);
    push_xfers(3, 1'b0);
    @(posedge clk); #1;
    dreq_in = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(dack_out == 0, "R2 dack low after edge 2", dack_out, 0);
    @(negedge clk);
    chk(dack_out == 1, "R2 dack high after edge 3", dack_out, 1);
    step(40);
    chk(xfers_seen == 3, "R4 chained transfers", xfers_seen, 3);
    chk(remaining == 0, "R7 count reached zero", int'(remaining), 0);
    chk(dack_out == 0, "R3 inactive after zero", dack_out, 0);
    chk(irq_seen == 1, "R8 one irq pulse", irq_seen, 1);
    dreq_in = 1'b0;
    step(4);

    // R4/R6/R8 chaining, four-beat bursts with stalls, count 2
    rdy_toggle = 1'b1;
    load(1'b0, 1'b1, 1'b1, 2);
    push_xfers(2, 1'b1);
    dreq_in = 1'b1;
    step(60);
    chk(xfers_seen == 5, "R6 burst transfers", xfers_seen, 5);
    chk(irq_seen == 2, "R8 irq once per load", irq_seen, 2);
    dreq_in = 1'b0;
    rdy_toggle = 1'b0;
    step(4);

    // R5/R9 waiting policy, four beats, count 2, irq off
    load(1'b1, 1'b1, 1'b0, 2);
    push_xfers(2, 1'b1);
    dreq_in = 1'b1;
    step(30);
    chk(dack_out == 1, "R5 dack held", dack_out, 1);
    chk(beat_valid == 0, "R5 no new beats while high", beat_valid, 0);
    chk(remaining == 1, "R7 one transfer done", int'(remaining), 1);
    load(1'b0, 1'b0, 1'b1, 9);
    step(2);
    chk(remaining == 1, "R9 write ignored while held", int'(remaining), 1);
    dreq_in = 1'b0;
    step(8);
    chk(dack_out == 0, "R5 dack drops after request low", dack_out, 0);
    chk(xfers_seen == 6, "R5 single transfer per request", xfers_seen, 6);
    rdy_toggle = 1'b1;
    dreq_in = 1'b1;
    step(40);
    chk(remaining == 0, "R7 second transfer", int'(remaining), 0);
    chk(dack_out == 1, "R5 held after last", dack_out, 1);
    dreq_in = 1'b0;
    rdy_toggle = 1'b0;
    step(8);
    chk(xfers_seen == 7, "R5 transfers total", xfers_seen, 7);
    chk(irq_seen == 2, "R8 no irq when disabled", irq_seen, 2);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule